// File: doc/BRIEF.md
# Packed Signed 16-bit Multiplier with Pair Accumulate

This unit multiplies two 64-bit operands lane by lane. Each operand holds four signed 16-bit lanes, and the unit forms four full 32-bit products. A mode input selects what goes out:

- the low 16 bits of every product,
- the high 16 bits of every product, or
- the sums of neighbouring full products, packed as two 32-bit lanes.

Data moves through a two-stage pipeline. The input side and the output side are both valid/ready streams. A beat enters when `in_valid` and `in_ready` are high together on a rising clock edge. A result leaves when `out_valid` and `out_ready` are high together on a rising clock edge.

Back-pressure stalls the whole pipeline at once. While the output holds an unaccepted result and `out_ready` is low, both stages freeze and `in_ready` drops. When `out_ready` is high, one beat can enter and one can leave on every clock. An input beat with `in_valid` high should keep its data and mode steady until it is accepted.

Top module: `pmul_top`

## Requirements
- R1: Lane i of each operand is bits 16*i+15:16*i, taken as a signed two's complement value. The four products are signed 16x16 to 32-bit multiplies of matching lanes.
- R2: With mode code 0 (low), result lane i (bits 16*i+15:16*i) is bits 15:0 of product i.
- R3: With mode code 1 (high), result lane i (bits 16*i+15:16*i) is bits 31:16 of product i.
- R4: With mode code 2 (pair sum), result bits 31:0 are product 0 plus product 1, and bits 63:32 are product 2 plus product 3. Each sum wraps in 32 bits, so all lanes at -32768 give 64'h8000000080000000.
- R5: Mode code 3 gives the same result as mode code 0.
- R6: While `out_ready` stays high, each accepted input appears on the output exactly two cycles later. Inputs can be accepted on every cycle, and results come out in order.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R8: After reset, `out_valid` is 0, `out_data` is 0 and `in_ready` is 1.
- R9: While `out_valid` is low, `out_data` keeps the last result delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can accept a beat this cycle |
| in_mode | input | 2 | 0 low half, 1 high half, 2 pair sum, 3 same as 0 |
| in_a | input | 64 | Operand A, four signed 16-bit lanes |
| in_b | input | 64 | Operand B, four signed 16-bit lanes |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | 64 | Packed result |

## Verification
The hardest state to reach from the ports is a full pipeline that stalls while both stages hold live beats of different modes. The stimulus reaches it by driving `out_ready` at random with a low probability while inputs arrive on most cycles. At the moment it releases, the first beat must leave and the second must not be lost or duplicated. Random stimulus alone almost never reaches the wrap corner of the pair sum, so directed beats with every lane at -32768 or 32767 are sent in each mode.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  typedef enum logic [1:0] {
    MODE_LO   = 2'd0,
    MODE_HI   = 2'd1,
    MODE_PAIR = 2'd2,
    MODE_ALT  = 2'd3
  } pmul_mode_e;
endpackage

// File: rtl/pmul_lane.sv
module pmul_lane #(
  parameter int LW = 16,
  localparam int PW = 2 * LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          load,
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  output logic [PW-1:0] prod
);
  logic signed [PW-1:0] full;
  assign full = $signed(a) * $signed(b);

  always_ff @(posedge clk) begin
    if (!rst_n)            prod <= '0;
    else if (adv && load)  prod <= full;
  end

  AST_ZERO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && load && (a == '0)) |=> (prod == '0)); // R1
endmodule

// File: rtl/pmul_ctrl.sv
module pmul_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic adv,
  output logic v1,
  output logic v2
);
  assign adv = !v2 || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid;
      v2 <= v1;
    end
  end

  AST_STAGE1_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && adv) |=> v1); // R6
  AST_STAGE2_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && adv) |=> v2); // R6
endmodule

// File: rtl/pmul_combine.sv
module pmul_combine
  import pmul_pkg::*;
#(
  parameter int LW    = 16,
  parameter int LANES = 4,
  localparam int PW    = 2 * LW,
  localparam int DW    = LW * LANES,
  localparam int PAIRS = LANES / 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      adv,
  input  logic                      load,
  input  logic [1:0]                mode,
  input  logic [LANES-1:0][PW-1:0]  prods,
  output logic [DW-1:0]             result
);
  logic [DW-1:0] lo_v, hi_v, pair_v, sel;

  for (genvar i = 0; i < LANES; i++) begin : g_half
    assign lo_v[i*LW +: LW] = prods[i][LW-1:0];
    assign hi_v[i*LW +: LW] = prods[i][PW-1:LW];
  end

  for (genvar j = 0; j < PAIRS; j++) begin : g_pair
    assign pair_v[j*PW +: PW] = prods[2*j] + prods[2*j+1];
  end

  always_comb begin
    case (pmul_mode_e'(mode))
      MODE_HI:   sel = hi_v;
      MODE_PAIR: sel = pair_v;
      default:   sel = lo_v;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           result <= '0;
    else if (adv && load) result <= sel;
  end
endmodule

// File: rtl/pmul_top.sv
module pmul_top #(
  parameter int LW    = 16,
  parameter int LANES = 4,
  localparam int PW   = 2 * LW,
  localparam int DW   = LW * LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_mode,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic adv, v1, v2;
  logic [1:0] mode_q;
  logic [LANES-1:0][PW-1:0] prods;

  pmul_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .adv(adv), .v1(v1), .v2(v2)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pmul_lane #(.LW(LW)) u_lane (
      .clk(clk), .rst_n(rst_n), .adv(adv), .load(in_valid),
      .a(in_a[i*LW +: LW]), .b(in_b[i*LW +: LW]), .prod(prods[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               mode_q <= 2'd0;
    else if (adv && in_valid) mode_q <= in_mode;
  end

  pmul_combine #(.LW(LW), .LANES(LANES)) u_comb (
    .clk(clk), .rst_n(rst_n), .adv(adv), .load(v1), .mode(mode_q),
    .prods(prods), .result(out_data)
  );

  assign in_ready  = adv;
  assign out_valid = v2;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |=> (out_valid || $stable(out_data))); // R9
endmodule

// File: tb/tb_pmul_top.sv
module tb_pmul_top;
  localparam time CLK = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [1:0]  in_mode;
  logic [63:0] in_a, in_b;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  bit strict_lat = 1;
  logic [63:0] exp_q[$];
  int          cyc_q[$];
  logic [63:0] last_out = '0;

  always #(CLK/2) clk = ~clk;

  pmul_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, logic [1:0] m);
    logic [31:0] p [4];
    logic [63:0] r;
    for (int i = 0; i < 4; i++)
      p[i] = 32'(int'($signed(a[i*16 +: 16])) * int'($signed(b[i*16 +: 16])));
    for (int i = 0; i < 4; i++)
      r[i*16 +: 16] = (m == 2'd1) ? p[i][31:16] : p[i][15:0];
    if (m == 2'd2) begin
      r[31:0]  = p[0] + p[1];
      r[63:32] = p[2] + p[3];
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string mode_req(logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // One cycle: drive after the falling edge, observe handshakes 1 ns later.
  task automatic step(bit v, logic [1:0] m, logic [63:0] a, logic [63:0] b, bit rdy);
    logic [63:0] e;
    logic [63:0] held;
    bit stall;
    @(negedge clk);
    in_valid = v; in_mode = m; in_a = a; in_b = b; out_ready = rdy;
    #1;
    cyc++;
    check(in_ready == (!out_valid || out_ready), "R7 in_ready", 64'(in_ready),
          64'(!out_valid || out_ready));
    if (!out_valid)
      check(out_data == last_out, "R9 idle hold", out_data, last_out);
    if (in_valid && in_ready) begin
      exp_q.push_back(model(a, b, m));
      cyc_q.push_back(cyc);
    end
    stall = out_valid && !out_ready;
    held  = out_data;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R6 spurious output", out_data, 64'd0);
      end else begin
        e = exp_q.pop_front();
        check(out_data == e, "R1/R2/R3/R4/R5 data", out_data, e);
        if (strict_lat)
          check(cyc - cyc_q[0] == 2, "R6 latency", 64'(cyc - cyc_q[0]), 64'd2);
        void'(cyc_q.pop_front());
      end
      last_out = out_data;
    end
    if (stall) begin
      @(negedge clk);
      #1;
      check(out_valid && out_data == held, "R7 stall hold", out_data, held);
      #(CLK - 2ns);
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 8; k++) step(0, 2'd0, '0, '0, 1);
  endtask

  initial begin
    #(CLK * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 0; in_valid = 0; in_mode = 0; in_a = 0; in_b = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(out_valid == 0, "R8 valid", 64'(out_valid), 64'd0);
    check(out_data == 0, "R8 data", out_data, 64'd0);
    check(in_ready == 1, "R8 ready", 64'(in_ready), 64'd1);

    // Directed corners in every mode (R1..R5), back to back (R6)
    for (int m = 0; m < 4; m++) begin
      step(1, 2'(m), {4{16'h8000}}, {4{16'h8000}}, 1);
      step(1, 2'(m), {4{16'h7FFF}}, {4{16'h7FFF}}, 1);
      step(1, 2'(m), {4{16'h8000}}, {4{16'h7FFF}}, 1);
      step(1, 2'(m), 64'hFFFF_0001_0002_FFFE, 64'h0003_FFFF_8000_0005, 1);
    end
    drain();
    // R4 wrap corner, explicitly
    step(1, 2'd2, {4{16'h8000}}, {4{16'h8000}}, 1);
    step(0, 2'd0, '0, '0, 1);
    step(0, 2'd0, '0, '0, 1);
    check(last_out == 64'h8000_0000_8000_0000, "R4 wrap", last_out, 64'h8000_0000_8000_0000);
    // R5 alias
    step(1, 2'd3, 64'h1234_8765_0F0F_FFFF, 64'h0101_7FFF_F0F0_0002, 1);
    drain();
    check(last_out == model(64'h1234_8765_0F0F_FFFF, 64'h0101_7FFF_F0F0_0002, 2'd0),
          "R5 alias", last_out,
          model(64'h1234_8765_0F0F_FFFF, 64'h0101_7FFF_F0F0_0002, 2'd0));

    // Random, no back-pressure
    for (int n = 0; n < 400; n++)
      step(($urandom % 10) < 8, 2'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, 1);
    drain();

    // Random with back-pressure
    strict_lat = 0;
    for (int n = 0; n < 600; n++)
      step(($urandom % 10) < 9, 2'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
           ($urandom % 10) < 4);
    drain();
    check(exp_q.size() == 0, "R6 all delivered", 64'(exp_q.size()), 64'd0);
    check(out_valid == 0 && out_data == last_out, "R9 final hold", out_data, last_out);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule